// File: doc/BRIEF.md
# Processor Mode Control Register Unit

This block keeps the two mode control registers of a processor core (called CR0 and CR4 here) together with an extended feature register whose bits govern long mode. Software writes arrive as a single strobe carrying a register select and a 32-bit value. Each write updates the target register and refreshes the set of hidden mode flags that the rest of the core reads without decoding the registers itself.

Some writes have side effects. Setting paging while long mode is enabled switches long mode on, provided physical address extension is already on; otherwise the write is refused. Clearing paging while long mode is active switches it off and asks the fetch logic to cut the instruction pointer to 32 bits. Changes to the paging-related bits of either control register ask the translation cache to flush.

Long-mode status is a two-state machine. In `LM_LEGACY`, a committed CR0 write that sets PG while LME=1 and PAE=1 takes the `enter` transition to `LM_LONG`. In `LM_LONG`, a CR0 write that clears PG takes the `leave` transition back to `LM_LEGACY`. Every other input keeps the current state.

Top module: `mode_ctl_unit`

## Requirements
- R1: While reset is held and after it, CR0 reads 0x60000010, CR4 and the extended register read 0, the hidden flags read 0x02 (only addseg set), and the flush and truncate strobes are low.
- R2: Every committed CR0 write stores the written value with bit 4 forced to 1.
- R3: A committed CR0 write pulses `tlb_flush_o` when bit 31 (PG), bit 16 (WP) or bit 0 (PE) differs from its stored value. If none of these bits changes, no pulse is raised.
- R4: Entry into long mode happens on a CR0 write that sets PG from 0 to 1 while LME (extended bit 8) is 1 and CR4 bit 5 (PAE) is 1. It sets extended bit 10 (LMA) and hidden flag bit 2. If PAE is 0 at that moment, the write is refused: CR0, the flags and the flush strobe do not change.
- R5: A CR0 write that clears PG while LMA is 1 clears LMA, hidden bit 2 and hidden bit 3 (64-bit code). It also pulses `ip_trunc_o` for one cycle. Clearing PG while LMA is 0 raises no truncate pulse.
- R6: Hidden bit 0 follows CR0.PE after each CR0 write. Hidden bit 1 (addseg) is 1 when PE is 0 and 0 when PE is 1.
- R7: Hidden bits 4, 5 and 6 take CR0 bits 1, 2 and 3 (MP, EM, TS) on each CR0 write.
- R8: On a CR4 write, bit 9 (OSFXSR) is stored as 0 when `sse_ok` is 0. Hidden bit 7 follows the stored bit 9.
- R9: A CR4 write pulses `tlb_flush_o` when bit 7 (PGE), bit 5 (PAE) or bit 4 (PSE) changes.
- R10: Register and flag updates appear in the cycle after the strobe. `tlb_flush_o` is high for exactly that one cycle unless the next write also flushes.
- R11: A write to the extended register (select 2) stores only bits 8 (LME) and 11 (NXE). Bit 10 (LMA) is left unchanged by it.
- R12: Strobe `cs64_we` loads `cs64_val` into hidden bit 3 only while in `LM_LONG`. It is ignored in `LM_LEGACY`.
- R13: Select value 3 changes no register, flag or strobe. Selects are 0 for CR0, 1 for CR4 and 2 for the extended register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sse_ok | input | 1 | Static: SSE support present |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 CR0, 1 CR4, 2 extended, 3 none |
| wr_data | input | 32 | New register value |
| cs64_we | input | 1 | Load strobe for the 64-bit code flag |
| cs64_val | input | 1 | Value for the 64-bit code flag |
| cr0_o | output | 32 | Current CR0 |
| cr4_o | output | 32 | Current CR4 |
| efer_o | output | 32 | Current extended register (LMA in bit 10) |
| hflags_o | output | 8 | Hidden flags {osfxsr, ts, em, mp, cs64, lma, addseg, pe} |
| tlb_flush_o | output | 1 | One-cycle translation flush request |
| ip_trunc_o | output | 1 | One-cycle instruction-pointer truncate request |

## Verification
The checker takes `sse_ok` to be static, so that a stored OSFXSR bit is never left set with SSE support absent. It also takes the strobes to be synchronous with `clk`. The stimulus lowers `sse_ok` only after CR4 has been written with bit 9 clear. It drives every strobe on the falling edge, and it issues `cs64_we` outside CR0 writes, so that the 64-bit flag never has to be loaded in the same cycle as a mode change.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
    localparam int unsigned CR_W   = 32;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned HF_W   = 8;

    localparam int unsigned B0_PE  = 0;
    localparam int unsigned B0_MP  = 1;
    localparam int unsigned B0_EM  = 2;
    localparam int unsigned B0_TS  = 3;
    localparam int unsigned B0_ET  = 4;
    localparam int unsigned B0_WP  = 16;
    localparam int unsigned B0_PG  = 31;

    localparam int unsigned B4_PSE = 4;
    localparam int unsigned B4_PAE = 5;
    localparam int unsigned B4_PGE = 7;
    localparam int unsigned B4_FXS = 9;

    localparam int unsigned BX_LME = 8;
    localparam int unsigned BX_LMA = 10;
    localparam int unsigned BX_NXE = 11;

    localparam logic [SEL_W-1:0] SEL_CR0 = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CR4 = 2'd1;
    localparam logic [SEL_W-1:0] SEL_EXT = 2'd2;

    localparam logic [CR_W-1:0] EXT_WMASK = (CR_W'(1) << BX_LME) | (CR_W'(1) << BX_NXE);

    typedef enum logic [0:0] {
        LM_LEGACY = 1'b0,
        LM_LONG   = 1'b1
    } lm_state_e;

    // stored CR0 image: the extension-type bit always reads 1
    function automatic logic [CR_W-1:0] cr0_store(input logic [CR_W-1:0] v);
        return v | (CR_W'(1) << B0_ET);
    endfunction

    // {ts, em, mp, addseg, pe} derived from a stored CR0 image
    function automatic logic [4:0] cr0_flags(input logic [CR_W-1:0] v);
        return {v[B0_TS], v[B0_EM], v[B0_MP], ~v[B0_PE], v[B0_PE]};
    endfunction
endpackage

// File: rtl/mcu_cr0_path.sv
module mcu_cr0_path
    import mcu_pkg::*;
(
    input  logic            cur_pg,
    input  logic            cur_wp,
    input  logic            cur_pe,
    input  logic [CR_W-1:0] wdata,
    input  logic            lme,
    input  logic            lma,
    input  logic            pae,
    output logic [CR_W-1:0] nxt,
    output logic            flush,
    output logic            enter,
    output logic            leave,
    output logic            refuse
);
    logic pg_up;
    logic pg_down;

    always_comb begin
        nxt     = cr0_store(wdata);
        pg_up   = !cur_pg && wdata[B0_PG];
        pg_down = cur_pg && !wdata[B0_PG];
        flush   = (cur_pg != wdata[B0_PG]) || (cur_wp != wdata[B0_WP]) ||
                  (cur_pe != wdata[B0_PE]);
        enter   = pg_up && lme && pae;
        refuse  = pg_up && lme && !pae;
        leave   = pg_down && lma;
    end
endmodule

// File: rtl/mcu_cr4_path.sv
module mcu_cr4_path
    import mcu_pkg::*;
(
    input  logic            cur_pge,
    input  logic            cur_pae,
    input  logic            cur_pse,
    input  logic [CR_W-1:0] wdata,
    input  logic            sse_ok,
    output logic [CR_W-1:0] nxt,
    output logic            flush
);
    always_comb begin
        nxt = wdata;
        if (!sse_ok) nxt[B4_FXS] = 1'b0;
        flush = (cur_pge != wdata[B4_PGE]) || (cur_pae != wdata[B4_PAE]) ||
                (cur_pse != wdata[B4_PSE]);
    end
endmodule

// File: rtl/mcu_lm_fsm.sv
module mcu_lm_fsm
    import mcu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic leave,
    input  logic cs64_we,
    input  logic cs64_val,
    output logic lma,
    output logic cs64,
    output logic trunc
);
    lm_state_e state_q;
    lm_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_LEGACY: if (enter) state_d = LM_LONG;
            LM_LONG:   if (leave) state_d = LM_LEGACY;
            default:   state_d = LM_LEGACY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LM_LEGACY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs64  <= 1'b0;
            trunc <= 1'b0;
        end else begin
            trunc <= (state_q == LM_LONG) && leave;
            unique case (state_q)
                LM_LEGACY: cs64 <= 1'b0;
                LM_LONG: begin
                    if (leave)        cs64 <= 1'b0;
                    else if (cs64_we) cs64 <= cs64_val;
                end
                default: cs64 <= 1'b0;
            endcase
        end
    end

    assign lma = (state_q == LM_LONG);
endmodule

// File: rtl/mode_ctl_unit.sv
module mode_ctl_unit
    import mcu_pkg::*;
#(
    parameter logic [31:0] CR0_RST = 32'h6000_0010
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sse_ok,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        cs64_we,
    input  logic        cs64_val,
    output logic [31:0] cr0_o,
    output logic [31:0] cr4_o,
    output logic [31:0] efer_o,
    output logic [7:0]  hflags_o,
    output logic        tlb_flush_o,
    output logic        ip_trunc_o
);
    logic [CR_W-1:0] cr0_q, cr4_q, ext_q;
    logic [4:0]      f0_q;
    logic            fxs_q, flush_q;
    logic [CR_W-1:0] cr0_nxt, cr4_nxt;
    logic            f0_flush, f4_flush, lm_enter, lm_leave, lm_refuse;
    logic            lma, cs64, trunc;
    logic            wr_cr0, wr_cr4, wr_ext, cr0_commit;

    assign wr_cr0     = wr_en && (wr_sel == SEL_CR0);
    assign wr_cr4     = wr_en && (wr_sel == SEL_CR4);
    assign wr_ext     = wr_en && (wr_sel == SEL_EXT);
    assign cr0_commit = wr_cr0 && !lm_refuse;

    mcu_cr0_path u_cr0 (
        .cur_pg (cr0_q[B0_PG]),
        .cur_wp (cr0_q[B0_WP]),
        .cur_pe (cr0_q[B0_PE]),
        .wdata  (wr_data),
        .lme    (ext_q[BX_LME]),
        .lma    (lma),
        .pae    (cr4_q[B4_PAE]),
        .nxt    (cr0_nxt),
        .flush  (f0_flush),
        .enter  (lm_enter),
        .leave  (lm_leave),
        .refuse (lm_refuse)
    );

    mcu_cr4_path u_cr4 (
        .cur_pge (cr4_q[B4_PGE]),
        .cur_pae (cr4_q[B4_PAE]),
        .cur_pse (cr4_q[B4_PSE]),
        .wdata   (wr_data),
        .sse_ok  (sse_ok),
        .nxt     (cr4_nxt),
        .flush   (f4_flush)
    );

    mcu_lm_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .enter    (cr0_commit && lm_enter),
        .leave    (cr0_commit && lm_leave),
        .cs64_we  (cs64_we),
        .cs64_val (cs64_val),
        .lma      (lma),
        .cs64     (cs64),
        .trunc    (trunc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr0_q   <= cr0_store(CR0_RST);
            f0_q    <= cr0_flags(cr0_store(CR0_RST));
            cr4_q   <= '0;
            ext_q   <= '0;
            fxs_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            if (cr0_commit) begin
                cr0_q   <= cr0_nxt;
                f0_q    <= cr0_flags(cr0_nxt);
                flush_q <= f0_flush;
            end
            if (wr_cr4) begin
                cr4_q   <= cr4_nxt;
                fxs_q   <= cr4_nxt[B4_FXS];
                flush_q <= f4_flush;
            end
            if (wr_ext) ext_q <= wr_data & EXT_WMASK;
        end
    end

    assign cr0_o       = cr0_q;
    assign cr4_o       = cr4_q;
    assign efer_o      = ext_q | (CR_W'(lma) << BX_LMA);
    assign hflags_o    = {fxs_q, f0_q[4:2], cs64, lma, f0_q[1:0]};
    assign tlb_flush_o = flush_q;
    assign ip_trunc_o  = trunc;
endmodule

// File: rtl/mcu_checker.sv
module mcu_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic sse_ok,
    input logic cr0_et,
    input logic cr0_pg,
    input logic cr0_pe,
    input logic cr4_fxs,
    input logic ext_lma,
    input logic hf_pe,
    input logic hf_cs64,
    input logic tlb_flush,
    input logic ip_trunc
);
    a_r2_et_set: assert property (@(posedge clk) disable iff (rst) cr0_et);
    a_r8_fxs_gate: assert property (@(posedge clk) disable iff (rst) !sse_ok |-> !cr4_fxs);
    a_r6_pe_track: assert property (@(posedge clk) disable iff (rst) hf_pe == cr0_pe);
    a_r10_flush_cause: assert property (@(posedge clk) disable iff (rst) tlb_flush |-> $past(wr_en));
    a_r4_long_needs_pg: assert property (@(posedge clk) disable iff (rst) ext_lma |-> cr0_pg);
    a_r5_trunc_exit: assert property (@(posedge clk) disable iff (rst)
        ip_trunc |-> (!ext_lma && !cr0_pg && $past(ext_lma)));
    a_r12_cs64_long: assert property (@(posedge clk) disable iff (rst) hf_cs64 |-> ext_lma);
endmodule

bind mode_ctl_unit mcu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .sse_ok    (sse_ok),
    .cr0_et    (cr0_o[4]),
    .cr0_pg    (cr0_o[31]),
    .cr0_pe    (cr0_o[0]),
    .cr4_fxs   (cr4_o[9]),
    .ext_lma   (efer_o[10]),
    .hf_pe     (hflags_o[0]),
    .hf_cs64   (hflags_o[3]),
    .tlb_flush (tlb_flush_o),
    .ip_trunc  (ip_trunc_o)
);

// File: tb/mode_ctl_unit_test.sv
module mode_ctl_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sse_ok = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        cs64_we = 1'b0;
    logic        cs64_val = 1'b0;
    logic [31:0] cr0_o, cr4_o, efer_o;
    logic [7:0]  hflags_o;
    logic        tlb_flush_o, ip_trunc_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    mode_ctl_unit uut (
        .clk(clk), .rst(rst), .sse_ok(sse_ok), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cs64_we(cs64_we), .cs64_val(cs64_val), .cr0_o(cr0_o),
        .cr4_o(cr4_o), .efer_o(efer_o), .hflags_o(hflags_o),
        .tlb_flush_o(tlb_flush_o), .ip_trunc_o(ip_trunc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // strobe on a falling edge; results are sampled on the next falling edge
    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cr0", cr0_o, 32'h6000_0010);
        chk("R1 cr4", cr4_o, 0);
        chk("R1 ext", efer_o, 0);
        chk("R1 hflags", {24'd0, hflags_o}, 32'h02);
        chk("R1 strobes", {30'd0, tlb_flush_o, ip_trunc_o}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 cr0 after release", cr0_o, 32'h6000_0010);
        chk("R1 hflags after release", {24'd0, hflags_o}, 32'h02);
    endtask

    task automatic t_cr0_basic();
        wr(2'd0, 32'h0000_000E);
        chk("R2 et forced", cr0_o, 32'h0000_001E);
        chk("R7 fpu flags", {24'd0, hflags_o}, 32'h72);
        chk("R3 no flush", {31'd0, tlb_flush_o}, 0);
        wr(2'd0, 32'h0000_0011);
        chk("R6 pe set", {24'd0, hflags_o}, 32'h01);
        chk("R3 pe flush", {31'd0, tlb_flush_o}, 1);
        idle();
        chk("R10 flush one cycle", {31'd0, tlb_flush_o}, 0);
        wr(2'd0, 32'h0001_0011);
        chk("R3 wp flush", {31'd0, tlb_flush_o}, 1);
        wr(2'd0, 32'h0001_0011);
        chk("R3 same value no flush", {31'd0, tlb_flush_o}, 0);
    endtask

    task automatic t_cr4();
        wr(2'd1, 32'h0000_0020);
        chk("R9 pae flush", {31'd0, tlb_flush_o}, 1);
        wr(2'd1, 32'h0000_0220);
        chk("R8 osfxsr kept", cr4_o, 32'h0000_0220);
        chk("R8 fxs flag", {31'd0, hflags_o[7]}, 1);
        chk("R9 no flush", {31'd0, tlb_flush_o}, 0);
        wr(2'd3, 32'hFFFF_FFFF);
        chk("R13 sel3 cr0", cr0_o, 32'h0001_0011);
        chk("R13 sel3 cr4", cr4_o, 32'h0000_0220);
        chk("R13 sel3 ext", efer_o, 0);
        chk("R13 sel3 flush", {31'd0, tlb_flush_o}, 0);
    endtask

    task automatic t_long_mode();
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R11 ext mask", efer_o, 32'h0000_0900);
        wr(2'd1, 32'h0000_0200);
        wr(2'd0, 32'h8001_0011);
        chk("R4 refused cr0", cr0_o, 32'h0001_0011);
        chk("R4 refused ext", efer_o, 32'h0000_0900);
        chk("R4 refused flush", {31'd0, tlb_flush_o}, 0);
        wr(2'd1, 32'h0000_0220);
        wr(2'd0, 32'h8001_0011);
        chk("R4 entry cr0", cr0_o, 32'h8001_0011);
        chk("R4 entry ext", efer_o, 32'h0000_0D00);
        chk("R4 entry hflags", {24'd0, hflags_o}, 32'h85);
        chk("R3 pg flush", {31'd0, tlb_flush_o}, 1);
        wr(2'd2, 32'h0000_0100);
        chk("R11 lma kept", efer_o, 32'h0000_0500);
        @(negedge clk); cs64_we = 1'b1; cs64_val = 1'b1;
        @(negedge clk); cs64_we = 1'b0;
        chk("R12 cs64 load", {24'd0, hflags_o}, 32'h8D);
        wr(2'd0, 32'h0001_0011);
        chk("R5 exit ext", efer_o, 32'h0000_0100);
        chk("R5 exit hflags", {24'd0, hflags_o}, 32'h81);
        chk("R5 trunc pulse", {31'd0, ip_trunc_o}, 1);
        idle();
        chk("R5 trunc one cycle", {31'd0, ip_trunc_o}, 0);
    endtask

    task automatic t_legacy_paging();
        wr(2'd2, 32'h0000_0000);
        wr(2'd0, 32'h8001_0011);
        chk("R4 pg without lme", efer_o, 0);
        chk("R2 pg cr0", cr0_o, 32'h8001_0011);
        @(negedge clk); cs64_we = 1'b1; cs64_val = 1'b1;
        @(negedge clk); cs64_we = 1'b0;
        chk("R12 cs64 ignored", {31'd0, hflags_o[3]}, 0);
        wr(2'd0, 32'h0001_0011);
        chk("R5 no trunc legacy", {31'd0, ip_trunc_o}, 0);
    endtask

    task automatic t_no_sse();
        wr(2'd1, 32'h0000_0000);
        @(negedge clk); sse_ok = 1'b0;
        wr(2'd1, 32'h0000_0220);
        chk("R8 osfxsr dropped", cr4_o, 32'h0000_0020);
        chk("R8 fxs flag clear", {31'd0, hflags_o[7]}, 0);
        chk("R9 pae flush", {31'd0, tlb_flush_o}, 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        t_reset();
        t_cr0_basic();
        t_cr4();
        t_long_mode();
        t_legacy_paging();
        t_no_sse();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule